// File: doc/BRIEF.md
# Software Single-Step Debug Controller

This block tracks the software single-step state of a simple in-order core. It raises a step debug exception, with a 32-bit syndrome word, each time a stepped instruction completes. It also raises one when the core arrives at an instruction boundary already owing a step exception. The state is built from two bits. One is an enable qualifier that says stepping is active at the current privilege level. The other is a saved step bit that the core reloads on exception return. Together they give three states: inactive, active with no step owed (armed), and active with a step owed (pending).

The core reports each retiring instruction with a class tag: normal, system call, or load-exclusive. In the armed state one retirement clears the step bit and requests a step exception. The syndrome records that an instruction was stepped, and whether that instruction was a load-exclusive. A system call instead clears the step bit with no request, so that its own exception is entered in the pending state. The controller keeps the syndrome steady and raises no further request until the core acknowledges the exception. While stepping is enabled it also tells the fetch side that instruction blocks must not chain into one another.

Top module: `step_dbg_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, `step_bit`, `step_exc_req` and `syndrome` are all 0.
- R2: While `step_en` is 0 the state is inactive. Retirements of any class raise no request and leave `step_bit` unchanged.
- R3: With `step_en`=1 and `step_bit`=1, a retirement of class normal (code 0) or load-exclusive (code 2) is followed, one cycle later, by `step_exc_req`=1 and `step_bit`=0. The syndrome then has bit 24 (instruction valid) set to 1.
- R4: Syndrome bit 6 is 1 only when the stepped instruction was a load-exclusive (class code 2). It is 0 for a normal step and for a pending-entry request.
- R5: With `step_en`=1, `step_bit`=0, no outstanding exception and no `eret_valid`, a request is raised on the next cycle. Its syndrome has bits 24 and 6 both 0.
- R6: A system-call retirement (class code 1) in the armed state clears `step_bit` in the next cycle and raises no request in that cycle. The pending state then raises a request one cycle later.
- R7: Every requested syndrome has bits [5:0] = 0x22, bit 25 = 1, and bits [23:7] = 0.
- R8: Syndrome bits [31:26] hold 0x33 when `same_level` is 1 in the request-forming cycle, and 0x32 when it is 0.
- R9: `step_exc_req` is a one-cycle pulse. `syndrome` holds its value, and no new request is raised, until `exc_ack` is seen.
- R10: When `eret_valid` is asserted, `step_bit` takes `eret_step` from the next cycle on. A pending-entry request is not formed in the cycle of that write.
- R11: `step_fence` is 1 exactly while `step_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Stepping active for the current privilege level |
| eret_valid | input | 1 | Exception return writes the step bit |
| eret_step | input | 1 | Step bit value restored on exception return |
| retire_valid | input | 1 | One instruction retires this cycle |
| retire_cls | input | 2 | Class of the retiring instruction: 0 normal, 1 system call, 2 load-exclusive |
| same_level | input | 1 | Debug target level equals current level |
| exc_ack | input | 1 | Core has taken the requested step exception |
| step_exc_req | output | 1 | One-cycle step exception request |
| syndrome | output | 32 | Step exception syndrome word |
| step_bit | output | 1 | Current saved step bit |
| step_fence | output | 1 | Blocks may not chain while stepping |

## Verification
The assertions take for granted that the core never retires an instruction while the controller is in the pending state. They also assume no retirement happens between a request and its acknowledgement, since the core is busy entering the exception. The stimulus keeps to this. Every step completion or pending entry is followed by an acknowledgement before the next retirement. Each scenario either leaves stepping disabled or reloads the step bit through an exception return before retiring again.

// File: rtl/step_dbg_pkg.sv
package step_dbg_pkg;

    localparam int SYN_W = 32;

    typedef enum logic [1:0] {
        CLS_NORMAL  = 2'd0,
        CLS_SYSCALL = 2'd1,
        CLS_LDEX    = 2'd2
    } insn_cls_e;

    typedef enum logic [1:0] {
        ST_INACTIVE = 2'd0,
        ST_ARMED    = 2'd1,
        ST_PENDING  = 2'd2
    } step_state_e;

    typedef struct packed {
        logic [5:0]  ec;
        logic        il;
        logic        isv;
        logic [16:0] zero;
        logic        ex;
        logic [5:0]  status;
    } step_syn_t;

    localparam logic [5:0] EC_STEP_LOWER = 6'h32;
    localparam logic [5:0] EC_STEP_SAME  = 6'h33;
    localparam logic [5:0] STEP_STATUS   = 6'h22;

    function automatic step_state_e decode_state(logic en, logic sbit);
        if (!en)
            return ST_INACTIVE;
        return sbit ? ST_ARMED : ST_PENDING;
    endfunction

    function automatic step_syn_t make_syn(logic same, logic isv, logic ex);
        step_syn_t s;
        s.ec     = same ? EC_STEP_SAME : EC_STEP_LOWER;
        s.il     = 1'b1;
        s.isv    = isv;
        s.zero   = '0;
        s.ex     = ex;
        s.status = STEP_STATUS;
        return s;
    endfunction

endpackage

// File: rtl/step_bit_reg.sv
module step_bit_reg
    import step_dbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step_en,
    input  logic        eret_valid,
    input  logic        eret_step,
    input  logic        retire_valid,
    output logic        step_bit,
    output step_state_e state
);

    always_comb state = decode_state(step_en, step_bit);

    always_ff @(posedge clk) begin
        if (rst)
            step_bit <= 1'b0;
        else if (eret_valid)
            step_bit <= eret_step;
        else if (retire_valid && state == ST_ARMED)
            step_bit <= 1'b0;
    end

    p_eret_write_r10: assert property (@(posedge clk) disable iff (rst)
        eret_valid |=> step_bit == $past(eret_step));

    p_inactive_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !eret_valid) |=> $stable(step_bit));

endmodule

// File: rtl/step_req_ctl.sv
module step_req_ctl
    import step_dbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  step_state_e state,
    input  logic        retire_valid,
    input  logic [1:0]  retire_cls,
    input  logic        eret_valid,
    input  logic        exc_ack,
    output logic        fire,
    output logic        fire_isv,
    output logic        fire_ex,
    output logic        req,
    output logic        busy
);

    logic step_done;
    logic pend_entry;

    always_comb begin
        step_done  = (state == ST_ARMED) && retire_valid && !busy &&
                     (retire_cls != CLS_SYSCALL);
        pend_entry = (state == ST_PENDING) && !busy && !eret_valid &&
                     !retire_valid;
        fire       = step_done || pend_entry;
        fire_isv   = step_done;
        fire_ex    = step_done && (retire_cls == CLS_LDEX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            busy <= 1'b0;
        end else begin
            req <= fire;
            if (fire)
                busy <= 1'b1;
            else if (exc_ack)
                busy <= 1'b0;
        end
    end

    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    p_inactive_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INACTIVE) |=> !req);

    p_syscall_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && retire_valid && retire_cls == CLS_SYSCALL) |=> !req);

    p_step_req_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && retire_valid && !busy &&
         retire_cls != CLS_SYSCALL) |=> req);

    p_no_retire_pending_r5: assert property (@(posedge clk) disable iff (rst)
        !(retire_valid && state == ST_PENDING));

    p_no_retire_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !(retire_valid && busy));

endmodule

// File: rtl/step_syn_hold.sv
module step_syn_hold
    import step_dbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              same_level,
    input  logic              fire_isv,
    input  logic              fire_ex,
    input  logic              busy,
    input  logic              exc_ack,
    output logic [SYN_W-1:0]  syndrome
);

    step_syn_t syn_q;

    always_ff @(posedge clk) begin
        if (rst)
            syn_q <= '0;
        else if (fire)
            syn_q <= make_syn(same_level, fire_isv, fire_ex);
    end

    assign syndrome = syn_q;

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !exc_ack) |=> $stable(syndrome));

    p_status_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (syndrome[5:0] == STEP_STATUS && syndrome[25] &&
                  syndrome[23:7] == '0));

    p_ex_needs_isv_r4: assert property (@(posedge clk) disable iff (rst)
        syndrome[6] |-> syndrome[24]);

endmodule

// File: rtl/step_dbg_ctrl.sv
module step_dbg_ctrl
    import step_dbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step_en,
    input  logic        eret_valid,
    input  logic        eret_step,
    input  logic        retire_valid,
    input  logic [1:0]  retire_cls,
    input  logic        same_level,
    input  logic        exc_ack,
    output logic        step_exc_req,
    output logic [31:0] syndrome,
    output logic        step_bit,
    output logic        step_fence
);

    step_state_e state;
    logic        fire;
    logic        fire_isv;
    logic        fire_ex;
    logic        busy;

    step_bit_reg u_bit (
        .clk          (clk),
        .rst          (rst),
        .step_en      (step_en),
        .eret_valid   (eret_valid),
        .eret_step    (eret_step),
        .retire_valid (retire_valid),
        .step_bit     (step_bit),
        .state        (state)
    );

    step_req_ctl u_req (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .retire_valid (retire_valid),
        .retire_cls   (retire_cls),
        .eret_valid   (eret_valid),
        .exc_ack      (exc_ack),
        .fire         (fire),
        .fire_isv     (fire_isv),
        .fire_ex      (fire_ex),
        .req          (step_exc_req),
        .busy         (busy)
    );

    step_syn_hold u_syn (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .same_level (same_level),
        .fire_isv   (fire_isv),
        .fire_ex    (fire_ex),
        .busy       (busy),
        .exc_ack    (exc_ack),
        .syndrome   (syndrome)
    );

    assign step_fence = (state != ST_INACTIVE);

    p_fence_r11: assert property (@(posedge clk) disable iff (rst)
        step_exc_req |-> $past(step_fence));

endmodule

// File: tb/test_step_dbg_ctrl.sv
module test_step_dbg_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        step_en, eret_valid, eret_step, retire_valid;
    logic [1:0]  retire_cls;
    logic        same_level, exc_ack;
    logic        step_exc_req, step_bit, step_fence;
    logic [31:0] syndrome;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    step_dbg_ctrl i_step_dbg_ctrl (
        .clk          (clk),
        .rst          (rst),
        .step_en      (step_en),
        .eret_valid   (eret_valid),
        .eret_step    (eret_step),
        .retire_valid (retire_valid),
        .retire_cls   (retire_cls),
        .same_level   (same_level),
        .exc_ack      (exc_ack),
        .step_exc_req (step_exc_req),
        .syndrome     (syndrome),
        .step_bit     (step_bit),
        .step_fence   (step_fence)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        eret_valid   = 0;
        eret_step    = 0;
        retire_valid = 0;
        retire_cls   = 2'd0;
        exc_ack      = 0;
    endtask

    // acknowledge and disable stepping together
    task automatic ack_and_stop();
        exc_ack = 1;
        step_en = 0;
        tick();
        exc_ack = 0;
        tick();
        chk("R9 quiet after ack", {31'd0, step_exc_req}, 32'd0);
    endtask

    // reload step bit to 1 through exception return, stepping enabled
    task automatic arm(logic same);
        step_en    = 1;
        same_level = same;
        eret_valid = 1;
        eret_step  = 1;
        tick();
        eret_valid = 0;
        chk("R10 armed bit", {31'd0, step_bit}, 32'd1);
        chk("R10 no request on write", {31'd0, step_exc_req}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1;
        step_en = 0;
        same_level = 0;
        idle_inputs();
        tick();
        tick();
        rst = 0;
        chk("R1 step_bit", {31'd0, step_bit}, 32'd0);
        chk("R1 req", {31'd0, step_exc_req}, 32'd0);
        chk("R1 syndrome", syndrome, 32'd0);
    endtask

    task automatic t_eret_timing();
        step_en    = 0;
        eret_valid = 1;
        eret_step  = 1;
        #1;
        chk("R10 before edge", {31'd0, step_bit}, 32'd0);
        tick();
        eret_valid = 0;
        chk("R10 after edge", {31'd0, step_bit}, 32'd1);
    endtask

    task automatic t_inactive();
        step_en = 0;
        chk("R11 fence off", {31'd0, step_fence}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            retire_valid = 1;
            retire_cls   = 2'(i);
            tick();
            chk("R2 no request", {31'd0, step_exc_req}, 32'd0);
            chk("R2 bit kept", {31'd0, step_bit}, 32'd1);
        end
        retire_valid = 0;
    endtask

    task automatic t_step_normal();
        arm(1'b1);
        chk("R11 fence on", {31'd0, step_fence}, 32'd1);
        retire_valid = 1;
        retire_cls   = 2'd0;
        tick();
        retire_valid = 0;
        chk("R3 request", {31'd0, step_exc_req}, 32'd1);
        chk("R3 bit cleared", {31'd0, step_bit}, 32'd0);
        chk("R3 R7 R8 syndrome", syndrome, 32'hCF000022);
        tick();
        chk("R9 pulse", {31'd0, step_exc_req}, 32'd0);
        ack_and_stop();
    endtask

    task automatic t_step_ldex();
        arm(1'b0);
        retire_valid = 1;
        retire_cls   = 2'd2;
        tick();
        retire_valid = 0;
        chk("R4 request", {31'd0, step_exc_req}, 32'd1);
        chk("R4 R8 syndrome", syndrome, 32'hCB000062);
        ack_and_stop();
    endtask

    task automatic t_pending_entry();
        // step_bit is 0 here; enabling stepping enters the pending state
        step_en    = 1;
        same_level = 0;
        tick();
        chk("R5 request", {31'd0, step_exc_req}, 32'd1);
        chk("R5 R8 syndrome", syndrome, 32'hCA000022);
        ack_and_stop();
    endtask

    task automatic t_syscall();
        arm(1'b1);
        retire_valid = 1;
        retire_cls   = 2'd1;
        tick();
        retire_valid = 0;
        chk("R6 no request", {31'd0, step_exc_req}, 32'd0);
        chk("R6 bit cleared", {31'd0, step_bit}, 32'd0);
        tick();
        chk("R6 pending request", {31'd0, step_exc_req}, 32'd1);
        chk("R6 syndrome", syndrome, 32'hCE000022);
        ack_and_stop();
    endtask

    task automatic t_hold_ack();
        step_en    = 1;
        same_level = 1;
        tick();
        chk("R9 first request", {31'd0, step_exc_req}, 32'd1);
        same_level = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R9 no repeat", {31'd0, step_exc_req}, 32'd0);
            chk("R9 held syndrome", syndrome, 32'hCE000022);
        end
        exc_ack = 1;
        tick();
        exc_ack = 0;
        chk("R9 not yet", {31'd0, step_exc_req}, 32'd0);
        tick();
        chk("R9 re-request after ack", {31'd0, step_exc_req}, 32'd1);
        chk("R8 new level", syndrome, 32'hCA000022);
        ack_and_stop();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_eret_timing();
        t_inactive();
        t_step_normal();
        t_step_ldex();
        t_pending_entry();
        t_syscall();
        t_hold_ack();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule